// File: doc/BRIEF.md
# ADC Conversion Sequencer Front-End

This block sits between a byte-wide register bus and an external analog-to-digital conversion core. Software programs a channel number, a clock select, a decimation ratio and a settle delay, turns the block on through an enable bit, and then writes a request bit. The block then waits out the programmed settle delay, gives the converter a one-cycle start pulse, and waits for the converter's done strobe.

When the done strobe arrives, the 16-bit sample is latched into two byte registers. An end-of-conversion flag is set and an interrupt pulse is raised. Two status bytes report the end-of-conversion flag, the pending request and the sequencer state. Clearing the enable bit aborts any conversion in flight and returns the block to idle. The converter itself is modelled only as a done/data handshake.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00. This covers both status bytes, the configuration registers and both result bytes. `conv_start` and `irq_eoc` are low.
- R2: The configuration registers read back what was written.
  - Channel is at 0x48 (8 bits) and drives `conv_chan`.
  - The digital parameter register is at 0x50. Clock select is in bits 1:0 and drives `conv_clksel`. Decimation select is in bits 3:2 and drives `conv_decim`. Bits 7:4 read 0.
  - Settle delay is at 0x51 (8 bits).
  - Enable is bit 7 of 0x46, and the other bits of 0x46 read 0.
  - An unmapped offset reads 0x00.
- R3: A write with bit 7 set to the request register at 0x52 is ignored while the enable bit is clear. No start pulse follows, and status byte 1 (0x08) bit 1 stays 0.
- R4: A request accepted from idle has these effects from the next cycle:
  - Status byte 1 reads 0x02: bit 1 is request pending, and bit 0, end-of-conversion, is cleared.
  - Status byte 2 (0x09) reads 0x10: bits 5:4 hold the sequencer state, with idle=0, settling=1 and converting=2.
  - Status byte 1 bits 7:2 and status byte 2 bits 3:0 always read 0.
- R5: For a settle value S, `conv_start` is high for exactly one cycle, in the cycle that begins S+1 clock edges after the edge that accepted the request. In that same cycle the pending bit reads 0 and the sequencer state reads 2.
- R6: A done strobe in the converting state latches `conv_data` on that edge. The low byte reads at 0x60 and the high byte at 0x61. From the next cycle:
  - status byte 1 bit 0 reads 1;
  - `irq_eoc` is high for exactly one cycle;
  - the state returns to idle.
- R7: A write to 0x46 with bit 7 clear aborts a request in progress. From the next cycle the state reads idle and the pending bit reads 0. No start pulse follows.
- R8: A done strobe outside the converting state is ignored. The result bytes, the end-of-conversion bit and `irq_eoc` are unchanged.
- R9: A request written while the sequencer is settling or converting is ignored. Only the one start pulse of the first request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 8 | Selected channel |
| conv_decim | output | 2 | Decimation ratio select |
| conv_clksel | output | 2 | Converter clock select |
| conv_done | input | 1 | Conversion done strobe |
| conv_data | input | 16 | Conversion result, valid with `conv_done` |
| irq_eoc | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
Register writes land on the clock edge that samples the strobe. Status reflects an accepted request one cycle later. The start pulse appears S+1 edges after the accepting edge. The result, the end-of-conversion bit and the interrupt are visible in the cycle after the done strobe, and the interrupt is gone one cycle after that.

The bench drives inputs on the falling edge and reads registers combinationally on the falling edge. It measures the start delay by counting edges from the end of the write. The start pulse width, the interrupt width and the absence of a start after an ignored or aborted request are observed through a falling-edge start counter.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int BYTE_W   = 8;
    localparam int RES_W    = 16;
    localparam int RES_BYTES = RES_W / BYTE_W;

    localparam logic [BYTE_W-1:0] OFS_STAT1  = 8'h08;
    localparam logic [BYTE_W-1:0] OFS_STAT2  = 8'h09;
    localparam logic [BYTE_W-1:0] OFS_ENA    = 8'h46;
    localparam logic [BYTE_W-1:0] OFS_CHAN   = 8'h48;
    localparam logic [BYTE_W-1:0] OFS_DIG    = 8'h50;
    localparam logic [BYTE_W-1:0] OFS_SETTLE = 8'h51;
    localparam logic [BYTE_W-1:0] OFS_REQ    = 8'h52;
    localparam logic [BYTE_W-1:0] OFS_RES0   = 8'h60;

    localparam int ENA_BIT = 7;
    localparam int REQ_BIT = 7;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_SETTLE  = 2'd1,
        SEQ_CONVERT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              enable;
        logic [BYTE_W-1:0] chan;
        logic [1:0]        decim;
        logic [1:0]        clksel;
        logic [BYTE_W-1:0] settle;
    } seq_cfg_t;

    function automatic logic [BYTE_W-1:0] pack_stat1(input logic eoc, input logic pend);
        return {6'b0, pend, eoc};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_stat2(input seq_state_e st);
        return {2'b00, st, 4'h0};
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output seq_cfg_t          cfg,
    output logic              req_wr,
    output logic              ena_off
);
    // Decoded write strobes
    logic wr_ena, wr_chan, wr_dig, wr_settle;

    assign wr_ena    = we && (addr == OFS_ENA);
    assign wr_chan   = we && (addr == OFS_CHAN);
    assign wr_dig    = we && (addr == OFS_DIG);
    assign wr_settle = we && (addr == OFS_SETTLE);

    assign req_wr  = we && (addr == OFS_REQ) && wdata[REQ_BIT];
    assign ena_off = wr_ena && !wdata[ENA_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (wr_ena)    cfg.enable <= wdata[ENA_BIT];
            if (wr_chan)   cfg.chan   <= wdata;
            if (wr_dig) begin
                cfg.clksel <= wdata[1:0];
                cfg.decim  <= wdata[3:2];
            end
            if (wr_settle) cfg.settle <= wdata;
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_cfg_t         cfg,
    input  logic             req_wr,
    input  logic             ena_off,
    input  logic             conv_done,
    output seq_state_e       state,
    output logic             pend,
    output logic             start,
    output logic             accept,
    output logic             done_ok
);
    logic             kill;
    logic [CNT_W-1:0] cnt;

    assign kill    = ena_off || !cfg.enable;
    assign accept  = req_wr && cfg.enable && !kill && (state == SEQ_IDLE);
    assign done_ok = conv_done && !kill && (state == SEQ_CONVERT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            pend  <= 1'b0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            if (kill) begin
                state <= SEQ_IDLE;
                pend  <= 1'b0;
            end else begin
                unique case (state)
                    SEQ_IDLE: begin
                        if (accept) begin
                            state <= SEQ_SETTLE;
                            cnt   <= CNT_W'(cfg.settle);
                            pend  <= 1'b1;
                        end
                    end
                    SEQ_SETTLE: begin
                        if (cnt == '0) begin
                            start <= 1'b1;
                            pend  <= 1'b0;
                            state <= SEQ_CONVERT;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    SEQ_CONVERT: begin
                        if (done_ok) state <= SEQ_IDLE;
                    end
                    default: state <= SEQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             done_ok,
    input  logic [RES_W-1:0] data,
    output logic [RES_W-1:0] result,
    output logic             eoc,
    output logic             irq
);
    genvar gi;
    generate
        for (gi = 0; gi < RES_BYTES; gi++) begin : g_byte
            always_ff @(posedge clk) begin
                if (rst)
                    result[gi*BYTE_W +: BYTE_W] <= '0;
                else if (done_ok)
                    result[gi*BYTE_W +: BYTE_W] <= data[gi*BYTE_W +: BYTE_W];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            eoc <= 1'b0;
            irq <= 1'b0;
        end else begin
            irq <= done_ok;
            if (done_ok)     eoc <= 1'b1;
            else if (accept) eoc <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              conv_start,
    output logic [7:0]        conv_chan,
    output logic [1:0]        conv_decim,
    output logic [1:0]        conv_clksel,
    input  logic              conv_done,
    input  logic [15:0]       conv_data,
    output logic              irq_eoc
);
    seq_cfg_t          cfg_q;
    seq_state_e        seq_st;
    logic              req_wr, ena_off, accept, done_ok, pend_q, eoc_q;
    logic [RES_W-1:0]  res_q;

    adc_seq_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .cfg(cfg_q), .req_wr(req_wr), .ena_off(ena_off)
    );

    adc_seq_fsm #(.CNT_W(BYTE_W)) u_fsm (
        .clk(clk), .rst(rst), .cfg(cfg_q), .req_wr(req_wr), .ena_off(ena_off),
        .conv_done(conv_done), .state(seq_st), .pend(pend_q), .start(conv_start),
        .accept(accept), .done_ok(done_ok)
    );

    adc_seq_result u_res (
        .clk(clk), .rst(rst), .accept(accept), .done_ok(done_ok),
        .data(conv_data), .result(res_q), .eoc(eoc_q), .irq(irq_eoc)
    );

    assign conv_chan   = cfg_q.chan;
    assign conv_decim  = cfg_q.decim;
    assign conv_clksel = cfg_q.clksel;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_STAT1:  bus_rdata = pack_stat1(eoc_q, pend_q);
            OFS_STAT2:  bus_rdata = pack_stat2(seq_st);
            OFS_ENA:    bus_rdata = {cfg_q.enable, 7'b0};
            OFS_CHAN:   bus_rdata = cfg_q.chan;
            OFS_DIG:    bus_rdata = {4'b0, cfg_q.decim, cfg_q.clksel};
            OFS_SETTLE: bus_rdata = cfg_q.settle;
            default: begin
                for (int i = 0; i < RES_BYTES; i++)
                    if (bus_addr == OFS_RES0 + BYTE_W'(i))
                        bus_rdata = res_q[i*BYTE_W +: BYTE_W];
            end
        endcase
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       conv_start,
    input logic       conv_done,
    input logic       irq_eoc,
    input logic [1:0] state,
    input logic       pend,
    input logic       eoc,
    input logic       enable
);
    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_start_after_settle_R5: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (state == 2'd2) && !pend && ($past(state) == 2'd1));

    assert_pend_only_settling_R4: assert property (@(posedge clk) disable iff (rst)
        pend |-> (state == 2'd1));

    assert_eoc_after_done_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc) |-> $past(conv_done) && (state == 2'd0));

    assert_irq_with_eoc_R6: assert property (@(posedge clk) disable iff (rst)
        irq_eoc |-> eoc);

    assert_disabled_no_pend_R3: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !pend);

    assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state == 2'd0));
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
    .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
    .irq_eoc(irq_eoc), .state(seq_st), .pend(pend_q), .eoc(eoc_q),
    .enable(cfg_q.enable)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        conv_start, conv_done = 1'b0, irq_eoc;
    logic [7:0]  conv_chan;
    logic [1:0]  conv_decim, conv_clksel;
    logic [15:0] conv_data = '0;

    int tests = 0, fails = 0, starts = 0;
    bit finished = 0;

    adc_seq_ctrl uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) if (conv_start) starts++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse(input logic [15:0] d);
        conv_done = 1; conv_data = d;
        @(posedge clk); @(negedge clk);
        conv_done = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        foreach (uut.u_res.result[i]) ; // no-op keeps elaboration simple
        rd(8'h08, v); chk(v == 0, "R1 stat1", v, 0);
        rd(8'h09, v); chk(v == 0, "R1 stat2", v, 0);
        rd(8'h46, v); chk(v == 0, "R1 enable", v, 0);
        rd(8'h60, v); chk(v == 0, "R1 res lo", v, 0);
        rd(8'h61, v); chk(v == 0, "R1 res hi", v, 0);
        chk(conv_start == 0 && irq_eoc == 0, "R1 outputs", {conv_start, irq_eoc}, 0);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(8'h48, 8'h5A); rd(8'h48, v); chk(v == 8'h5A && conv_chan == 8'h5A, "R2 chan", v, 8'h5A);
        wr(8'h50, 8'hFE); rd(8'h50, v); chk(v == 8'h0E, "R2 dig", v, 8'h0E);
        chk(conv_decim == 2'd3 && conv_clksel == 2'd2, "R2 dig fields", {conv_decim, conv_clksel}, 4'hE);
        wr(8'h51, 8'h33); rd(8'h51, v); chk(v == 8'h33, "R2 settle", v, 8'h33);
        wr(8'h46, 8'hFF); rd(8'h46, v); chk(v == 8'h80, "R2 enable", v, 8'h80);
        rd(8'h20, v); chk(v == 0, "R2 unmapped", v, 0);
        wr(8'h46, 8'h00);
    endtask

    task automatic t_req_disabled;
        logic [7:0] v;
        int s0 = starts;
        wr(8'h51, 8'h00);
        wr(8'h52, 8'h80);
        rd(8'h08, v); chk(v == 0, "R3 stat1 after ignored req", v, 0);
        rd(8'h09, v); chk(v == 0, "R3 stat2 idle", v, 0);
        idle(10);
        chk(starts == s0, "R3 no start", starts - s0, 0);
    endtask

    task automatic t_conv(input int s, input logic [15:0] d);
        logic [7:0] v;
        int k = 0;
        wr(8'h46, 8'h80);
        wr(8'h51, 8'(s));
        wr(8'h52, 8'h80);
        rd(8'h08, v); chk(v == 8'h02, "R4 stat1 pending, eoc cleared", v, 8'h02);
        rd(8'h09, v); chk(v == 8'h10, "R4 stat2 settling", v, 8'h10);
        while (!conv_start && k < 300) begin
            @(posedge clk); @(negedge clk); k++;
        end
        chk(k == s + 1, "R5 start delay", k, s + 1);
        rd(8'h08, v); chk(v[1] == 0, "R5 pending cleared", v, 0);
        rd(8'h09, v); chk(v == 8'h20, "R5 converting", v, 8'h20);
        idle(1);
        chk(conv_start == 0, "R5 start one cycle", conv_start, 0);
        done_pulse(d);
        rd(8'h08, v); chk(v == 8'h01, "R6 eoc set", v, 1);
        chk(irq_eoc == 1, "R6 irq high", irq_eoc, 1);
        rd(8'h60, v); chk(v == d[7:0], "R6 result low", v, d[7:0]);
        rd(8'h61, v); chk(v == d[15:8], "R6 result high", v, d[15:8]);
        rd(8'h09, v); chk(v == 0, "R6 idle", v, 0);
        idle(1);
        chk(irq_eoc == 0, "R6 irq one cycle", irq_eoc, 0);
    endtask

    task automatic t_abort;
        logic [7:0] v;
        int s0;
        wr(8'h51, 8'd20);
        wr(8'h52, 8'h80);
        s0 = starts;
        idle(3);
        wr(8'h46, 8'h00);
        rd(8'h09, v); chk(v == 0, "R7 idle after abort", v, 0);
        rd(8'h08, v); chk(v[1] == 0, "R7 pending cleared", v, 0);
        idle(30);
        chk(starts == s0, "R7 no start after abort", starts - s0, 0);
        done_pulse(16'hAAAA);
        rd(8'h60, v); chk(v == 8'h34, "R8 done ignored after abort", v, 8'h34);
        chk(irq_eoc == 0, "R8 no irq", irq_eoc, 0);
    endtask

    task automatic t_done_idle;
        logic [7:0] v;
        wr(8'h46, 8'h80);
        done_pulse(16'h5555);
        rd(8'h61, v); chk(v == 8'h12, "R8 done in idle ignored", v, 8'h12);
        chk(irq_eoc == 0, "R8 no irq in idle", irq_eoc, 0);
    endtask

    task automatic t_busy_req;
        int s0 = starts;
        wr(8'h51, 8'd6);
        wr(8'h52, 8'h80);
        idle(2);
        wr(8'h52, 8'h80);
        idle(30);
        chk(starts - s0 == 1, "R9 single start", starts - s0, 1);
        wr(8'h52, 8'h80);
        idle(20);
        chk(starts - s0 == 1, "R9 req while converting ignored", starts - s0, 1);
        done_pulse(16'h0F0F);
    endtask

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_req_disabled();
        t_conv(0, 16'hBEEF);
        t_conv(4, 16'h1234);
        t_abort();
        t_done_idle();
        t_busy_req();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule